// File: doc/BRIEF.md
# CCD Electronic Shutter Controller

This block decides, field by field, when the substrate-discharge pulse (VSUB) of a progressive-scan CCD fires. It also decides whether the ternary readout pulse of the field must be withheld. Software commits a configuration word with three fields: a 2-bit shutter mode, an 8-bit count of whole fields, and a 10-bit line value. The surrounding timing generator supplies four more inputs: the drive mode (monitoring or recording), an expose request, the current line and pixel-clock counts, and a one-cycle field-start strobe.

The exposure has two parts. One is a whole number of fields, set by the frame count. The other is a position within a field, set by the line value. The line value is the line at which shutter pulsing stops. In monitoring drive that line carries a fixed offset. The block flags illegal line values and clamps them to the nearest legal bound. While a multi-field exposure runs, it refuses new configuration and reports that it is blocked. In the hold mode it withholds readout for the field, so the exposure carries on into the next field.

Top module: `shut_ctrl`

## Requirements
- R1: After a synchronous reset, `vsub_o`, `rd_suppress_o`, `cfg_err_o` and `cfg_blocked_o` are all 0.
- R2: Shutter mode values 2'b00 and 2'b10 produce no shutter VSUB. Only the expose pulse of R9 can appear in these modes.
- R3: A VSUB-active line drives `vsub_o` high for pixel counts 44 through 128 and low for all other counts. `vsub_o` is registered, so it reflects the counts that were presented one clock earlier.
- R4: In mode 2'b01 the effective line is computed from the clamped line value. In recording drive (`drive_rec_i`=1) it equals the clamped value. In monitoring drive (`drive_rec_i`=0) it equals the clamped value minus 0x106. On odd fields (`field_even_i`=0), lines below the effective line are VSUB-active. On even fields the effective line itself is VSUB-active as well.
- R5: In mode 2'b01 a line value above 0x20C is used as 0x20C. In monitoring drive, a line value below 0x107 is used as 0x107. Either case raises `cfg_err_o` one clock after it arises. In any other mode `cfg_err_o` stays 0.
- R6: An accepted commit in mode 2'b01 loads the frame counter with the frame count; in any other mode it loads 0. `cfg_blocked_o` is 1 whenever the counter is nonzero. A commit that arrives while the block is blocked changes nothing.
- R7: Each field-start strobe decrements a nonzero counter. A field that starts with a nonzero counter is a hold field: it has no shutter VSUB, and `rd_suppress_o` is 1 during it.
- R8: Mode 2'b11 holds `rd_suppress_o` at 1 and produces no shutter VSUB.
- R9: While `expose_i` is 1, line RD_LINE+1 (line 9 by default) is VSUB-active in every mode. This gives exactly one pulse on that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_commit_i | input | 1 | One-cycle strobe that commits the configuration fields |
| cfg_mode_i | input | 2 | Shutter mode: 00/10 off, 01 range shutter, 11 readout hold |
| cfg_frames_i | input | 8 | Number of whole fields added to the exposure |
| cfg_line_i | input | 10 | Line at which shutter pulsing stops |
| drive_rec_i | input | 1 | 1 = recording drive, 0 = monitoring drive |
| expose_i | input | 1 | Request for the single exposure-start pulse |
| field_start_i | input | 1 | One-cycle strobe at the start of each field |
| field_even_i | input | 1 | 1 during even fields |
| line_cnt_i | input | 10 | Current line within the field |
| pix_cnt_i | input | 10 | Pixel clocks since the horizontal sync falling edge |
| vsub_o | output | 1 | VSUB enable, registered |
| rd_suppress_o | output | 1 | Withhold the readout pulse for this field |
| cfg_err_o | output | 1 | Committed line value was out of range and has been clamped |
| cfg_blocked_o | output | 1 | Multi-field exposure running; commits are refused |

## Verification
The assertions assume that a commit and a field-start strobe never arrive in the same clock. They also assume that the line and pixel counts stay inside one field and one line, and that the drive mode changes only between commits. The bench drives every input on the falling edge, so each value is held across a full rising edge. It pulses commits and field starts in separate cycles. It walks the pixel count across both edges of the pulse window, and the line count across both sides of the effective line, in both drive modes and on both field parities.

// File: rtl/shut_pkg.sv
package shut_pkg;
  typedef enum logic [1:0] {
    SH_OFF_A = 2'b00,
    SH_RANGE = 2'b01,
    SH_OFF_B = 2'b10,
    SH_HOLD  = 2'b11
  } shut_mode_e;

  localparam int unsigned LINE_W_D   = 10;
  localparam int unsigned PIX_W_D    = 10;
  localparam int unsigned FRM_W_D    = 8;
  localparam int unsigned LINE_MAX_D = 'h20C;
  localparam int unsigned MON_OFS_D  = 'h106;
endpackage

// File: rtl/shut_cfg.sv
module shut_cfg
  import shut_pkg::*;
#(
  parameter int unsigned LINE_W   = LINE_W_D,
  parameter int unsigned LINE_MAX = LINE_MAX_D,
  parameter int unsigned MON_OFS  = MON_OFS_D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept_i,
  input  shut_mode_e        mode_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic              drive_rec_i,
  output shut_mode_e        mode_o,
  output logic [LINE_W-1:0] eff_line_o,
  output logic              err_o
);
  localparam logic [LINE_W-1:0] HI_BOUND = LINE_W'(LINE_MAX);
  localparam logic [LINE_W-1:0] LO_BOUND = LINE_W'(MON_OFS + 1);
  localparam logic [LINE_W-1:0] OFS      = LINE_W'(MON_OFS);

  shut_mode_e        mode_r;
  logic [LINE_W-1:0] line_r;
  logic              over_hi, under_lo;
  logic [LINE_W-1:0] clamped;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_r <= SH_OFF_A;
      line_r <= '0;
    end else if (accept_i) begin
      mode_r <= mode_i;
      line_r <= line_i;
    end
  end

  always_comb begin
    over_hi  = line_r > HI_BOUND;
    under_lo = !drive_rec_i && (line_r < LO_BOUND);
    if (over_hi)       clamped = HI_BOUND;
    else if (under_lo) clamped = LO_BOUND;
    else               clamped = line_r;
    eff_line_o = drive_rec_i ? clamped : clamped - OFS;
  end

  always_ff @(posedge clk) begin
    if (rst) err_o <= 1'b0;
    else     err_o <= (mode_r == SH_RANGE) && (over_hi || under_lo);
  end

  assign mode_o = mode_r;

  // R5
  err_only_range_chk: assert property (@(posedge clk) disable iff (rst)
    err_o |-> $past(mode_r) == SH_RANGE);

  // R4
  eff_in_field_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_r == SH_RANGE) |-> eff_line_o <= HI_BOUND);
endmodule

// File: rtl/shut_frame.sv
module shut_frame
  import shut_pkg::*;
#(
  parameter int unsigned FRM_W = FRM_W_D
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept_i,
  input  shut_mode_e       mode_i,
  input  logic [FRM_W-1:0] frames_i,
  input  logic             field_start_i,
  output logic             hold_o,
  output logic             blocked_o
);
  logic [FRM_W-1:0] cnt_r;
  logic             hold_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_r  <= '0;
      hold_r <= 1'b0;
    end else if (accept_i) begin
      cnt_r <= (mode_i == SH_RANGE) ? frames_i : '0;
    end else if (field_start_i) begin
      hold_r <= (cnt_r != '0);
      if (cnt_r != '0) cnt_r <= cnt_r - 1'b1;
    end
  end

  assign hold_o    = hold_r;
  assign blocked_o = (cnt_r != '0);

  // R7
  cnt_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (field_start_i && !accept_i && cnt_r != '0) |=> cnt_r == $past(cnt_r) - 1'b1);

  // R6
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!field_start_i && !accept_i) |=> $stable(cnt_r));
endmodule

// File: rtl/shut_vsub.sv
module shut_vsub
  import shut_pkg::*;
#(
  parameter int unsigned LINE_W   = LINE_W_D,
  parameter int unsigned PIX_W    = PIX_W_D,
  parameter int unsigned VS_START = 44,
  parameter int unsigned VS_STOP  = 129,
  parameter int unsigned RD_LINE  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  shut_mode_e        mode_i,
  input  logic              hold_i,
  input  logic [LINE_W-1:0] eff_line_i,
  input  logic [LINE_W-1:0] line_cnt_i,
  input  logic [PIX_W-1:0]  pix_cnt_i,
  input  logic              field_even_i,
  input  logic              expose_i,
  output logic              vsub_o,
  output logic              rd_suppress_o
);
  localparam logic [PIX_W-1:0]  WIN_LO   = PIX_W'(VS_START);
  localparam logic [PIX_W-1:0]  WIN_HI   = PIX_W'(VS_STOP);
  localparam logic [LINE_W-1:0] EXP_LINE = LINE_W'(RD_LINE + 1);

  logic in_win, shut_line, exp_line;

  always_comb begin
    in_win    = (pix_cnt_i >= WIN_LO) && (pix_cnt_i < WIN_HI);
    shut_line = (mode_i == SH_RANGE) && !hold_i &&
                ((line_cnt_i < eff_line_i) ||
                 (field_even_i && line_cnt_i == eff_line_i));
    exp_line  = expose_i && (line_cnt_i == EXP_LINE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vsub_o        <= 1'b0;
      rd_suppress_o <= 1'b0;
    end else begin
      vsub_o        <= in_win && (shut_line || exp_line);
      rd_suppress_o <= (mode_i == SH_HOLD) || hold_i;
    end
  end

  // R3
  vsub_window_chk: assert property (@(posedge clk) disable iff (rst)
    vsub_o |-> ($past(pix_cnt_i) >= WIN_LO && $past(pix_cnt_i) < WIN_HI));

  // R2
  vsub_source_chk: assert property (@(posedge clk) disable iff (rst)
    vsub_o |-> ($past(mode_i) == SH_RANGE || $past(expose_i)));

  // R8
  hold_mode_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_i) == SH_HOLD) |-> rd_suppress_o);
endmodule

// File: rtl/shut_ctrl.sv
module shut_ctrl
  import shut_pkg::*;
#(
  parameter int unsigned LINE_W   = LINE_W_D,
  parameter int unsigned PIX_W    = PIX_W_D,
  parameter int unsigned FRM_W    = FRM_W_D,
  parameter int unsigned LINE_MAX = LINE_MAX_D,
  parameter int unsigned MON_OFS  = MON_OFS_D,
  parameter int unsigned VS_START = 44,
  parameter int unsigned VS_STOP  = 129,
  parameter int unsigned RD_LINE  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_commit_i,
  input  logic [1:0]        cfg_mode_i,
  input  logic [FRM_W-1:0]  cfg_frames_i,
  input  logic [LINE_W-1:0] cfg_line_i,
  input  logic              drive_rec_i,
  input  logic              expose_i,
  input  logic              field_start_i,
  input  logic              field_even_i,
  input  logic [LINE_W-1:0] line_cnt_i,
  input  logic [PIX_W-1:0]  pix_cnt_i,
  output logic              vsub_o,
  output logic              rd_suppress_o,
  output logic              cfg_err_o,
  output logic              cfg_blocked_o
);
  shut_mode_e        mode_in, mode_cur;
  logic              accept, hold, blocked;
  logic [LINE_W-1:0] eff_line;

  assign mode_in = shut_mode_e'(cfg_mode_i);
  assign accept  = cfg_commit_i && !blocked;

  shut_cfg #(.LINE_W(LINE_W), .LINE_MAX(LINE_MAX), .MON_OFS(MON_OFS)) u_cfg (
    .clk(clk), .rst(rst), .accept_i(accept), .mode_i(mode_in),
    .line_i(cfg_line_i), .drive_rec_i(drive_rec_i),
    .mode_o(mode_cur), .eff_line_o(eff_line), .err_o(cfg_err_o)
  );

  shut_frame #(.FRM_W(FRM_W)) u_frame (
    .clk(clk), .rst(rst), .accept_i(accept), .mode_i(mode_in),
    .frames_i(cfg_frames_i), .field_start_i(field_start_i),
    .hold_o(hold), .blocked_o(blocked)
  );

  shut_vsub #(.LINE_W(LINE_W), .PIX_W(PIX_W), .VS_START(VS_START),
              .VS_STOP(VS_STOP), .RD_LINE(RD_LINE)) u_vsub (
    .clk(clk), .rst(rst), .mode_i(mode_cur), .hold_i(hold),
    .eff_line_i(eff_line), .line_cnt_i(line_cnt_i), .pix_cnt_i(pix_cnt_i),
    .field_even_i(field_even_i), .expose_i(expose_i),
    .vsub_o(vsub_o), .rd_suppress_o(rd_suppress_o)
  );

  assign cfg_blocked_o = blocked;

  // R6
  refuse_when_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_commit_i && blocked) |=> $stable(mode_cur));

  // R7
  hold_no_vsub_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(hold) && !$past(expose_i)) |-> !vsub_o);
endmodule

// File: tb/shut_ctrl_bench.sv
module shut_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_commit = 1'b0;
  logic [1:0] cfg_mode = 2'b00;
  logic [7:0] cfg_frames = '0;
  logic [9:0] cfg_line = '0;
  logic       drive_rec = 1'b1;
  logic       expose = 1'b0;
  logic       field_start = 1'b0;
  logic       field_even = 1'b0;
  logic [9:0] line_cnt = '0;
  logic [9:0] pix_cnt = '0;
  logic       vsub, rd_sup, cfg_err, blocked;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shut_ctrl u_shut_ctrl (
    .clk(clk), .rst(rst), .cfg_commit_i(cfg_commit), .cfg_mode_i(cfg_mode),
    .cfg_frames_i(cfg_frames), .cfg_line_i(cfg_line), .drive_rec_i(drive_rec),
    .expose_i(expose), .field_start_i(field_start), .field_even_i(field_even),
    .line_cnt_i(line_cnt), .pix_cnt_i(pix_cnt), .vsub_o(vsub),
    .rd_suppress_o(rd_sup), .cfg_err_o(cfg_err), .cfg_blocked_o(blocked)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic commit(input logic [1:0] m, input logic [7:0] f, input logic [9:0] l);
    @(negedge clk);
    cfg_mode = m; cfg_frames = f; cfg_line = l; cfg_commit = 1'b1;
    @(negedge clk);
    cfg_commit = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic probe(input logic [9:0] ln, input logic [9:0] px, input logic even,
                       input logic exp, input string req);
    @(negedge clk);
    line_cnt = ln; pix_cnt = px; field_even = even;
    @(negedge clk);
    check(req, vsub, exp);
  endtask

  task automatic pulse_field;
    @(negedge clk);
    field_start = 1'b1;
    @(negedge clk);
    field_start = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 vsub", vsub, 1'b0);
    check("R1 rd_suppress", rd_sup, 1'b0);
    check("R1 err", cfg_err, 1'b0);
    check("R1 blocked", blocked, 1'b0);
  endtask

  task automatic t_off_modes;
    drive_rec = 1'b1;
    commit(2'b00, 8'd0, 10'h100);
    probe(10'd0, 10'd60, 1'b0, 1'b0, "R2 mode00");
    commit(2'b10, 8'd0, 10'h100);
    probe(10'd0, 10'd60, 1'b1, 1'b0, "R2 mode10");
    check("R2 no suppress", rd_sup, 1'b0);
  endtask

  task automatic t_window_rec;
    drive_rec = 1'b1;
    commit(2'b01, 8'd0, 10'h010);
    probe(10'd5, 10'd43, 1'b0, 1'b0, "R3 pix43");
    probe(10'd5, 10'd44, 1'b0, 1'b1, "R3 pix44");
    probe(10'd5, 10'd128, 1'b0, 1'b1, "R3 pix128");
    probe(10'd5, 10'd129, 1'b0, 1'b0, "R3 pix129");
    probe(10'h00F, 10'd60, 1'b0, 1'b1, "R4 rec below line");
    probe(10'h010, 10'd60, 1'b0, 1'b0, "R4 rec odd at line");
    probe(10'h010, 10'd60, 1'b1, 1'b1, "R4 rec even at line");
    probe(10'h011, 10'd60, 1'b1, 1'b0, "R4 rec even past line");
    check("R5 legal no err", cfg_err, 1'b0);
  endtask

  task automatic t_monitor;
    drive_rec = 1'b0;
    commit(2'b01, 8'd0, 10'h110);
    probe(10'd9, 10'd60, 1'b0, 1'b1, "R4 mon below eff");
    probe(10'd10, 10'd60, 1'b0, 1'b0, "R4 mon odd at eff");
    check("R5 mon legal no err", cfg_err, 1'b0);
  endtask

  task automatic t_range;
    drive_rec = 1'b1;
    commit(2'b01, 8'd0, 10'h300);
    check("R5 high err", cfg_err, 1'b1);
    probe(10'h20B, 10'd60, 1'b0, 1'b1, "R5 clamp high below");
    probe(10'h20C, 10'd60, 1'b0, 1'b0, "R5 clamp high at");
    drive_rec = 1'b0;
    commit(2'b01, 8'd0, 10'h050);
    check("R5 low err", cfg_err, 1'b1);
    probe(10'd0, 10'd60, 1'b0, 1'b1, "R5 clamp low line0");
    probe(10'd1, 10'd60, 1'b0, 1'b0, "R5 clamp low line1");
    commit(2'b00, 8'd0, 10'h050);
    check("R5 err only mode01", cfg_err, 1'b0);
    drive_rec = 1'b1;
  endtask

  task automatic t_frames;
    drive_rec = 1'b1;
    commit(2'b01, 8'd2, 10'h020);
    check("R6 blocked", blocked, 1'b1);
    commit(2'b01, 8'd0, 10'h005);
    probe(10'h010, 10'd60, 1'b0, 1'b1, "R6 commit refused");
    check("R6 still blocked", blocked, 1'b1);
    pulse_field;
    check("R7 hold suppress f1", rd_sup, 1'b1);
    probe(10'd0, 10'd60, 1'b0, 1'b0, "R7 hold no vsub f1");
    check("R6 blocked f1", blocked, 1'b1);
    pulse_field;
    check("R7 hold suppress f2", rd_sup, 1'b1);
    check("R6 unblocked f2", blocked, 1'b0);
    pulse_field;
    check("R7 normal field", rd_sup, 1'b0);
    probe(10'd0, 10'd60, 1'b0, 1'b1, "R7 vsub resumes");
  endtask

  task automatic t_hold_mode;
    commit(2'b11, 8'd0, 10'h020);
    check("R8 suppress", rd_sup, 1'b1);
    probe(10'd0, 10'd60, 1'b0, 1'b0, "R8 no vsub");
  endtask

  task automatic t_expose;
    commit(2'b00, 8'd0, 10'h100);
    @(negedge clk);
    expose = 1'b1;
    probe(10'd9, 10'd60, 1'b0, 1'b1, "R9 expose line");
    probe(10'd9, 10'd130, 1'b0, 1'b0, "R9 expose outside window");
    probe(10'd8, 10'd60, 1'b0, 1'b0, "R9 readout line");
    probe(10'd10, 10'd60, 1'b0, 1'b0, "R9 line after");
    @(negedge clk);
    expose = 1'b0;
    probe(10'd9, 10'd60, 1'b0, 1'b0, "R9 no request");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_off_modes;
    t_window_rec;
    t_monitor;
    t_range;
    t_frames;
    t_hold_mode;
    t_expose;
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule